// File: doc/BRIEF.md
# Shared MD-Family Hash Step Datapath

This block carries out one elementary compression step per clock on five 32-bit working registers (A through E). It serves three hash algorithms: the 128-bit MD5 digest, the 160-bit SHA-1 digest, and one of the two lanes of the 160-bit RIPEMD-160 digest. All three run on one shared chain of adders and one shared rotator. A multiplexer in front of each register picks that register's next value according to the selected algorithm.

An outside sequencer supplies the rest of the hashing process. For each step it gives the algorithm code and the Boolean-function code. It also gives the message word already added to the round constant, and the rotate amount. At the start of a block it asserts `load` with a 160-bit chaining value. After that it pulses `step_en` once per step. Round counting, the message schedule, the constants and the final chaining addition are the sequencer's work, not this block's. A RIPEMD-160 engine uses two instances of the block, one for each lane.

Top module: `hash_step_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, all five registers become zero.
- R2: When `load` is high, the registers take `cv_in` at the next edge: A=[159:128], B=[127:96], C=[95:64], D=[63:32], E=[31:0]. `load` wins over `step_en` in the same cycle.
- R3: When both `load` and `step_en` are low, no register changes.
- R4: `fn_sel` picks the Boolean function F(B,C,D). The codes are: 0 B^C^D; 1 (B&C)|(~B&D); 2 majority (B&C)|(B&D)|(C&D); 3 (B&D)|(C&~D); 4 C^(B|~D); 5 (B|~C)^D; 6 B^(C|~D). Code 7 gives zero.
- R5: A step with `alg_sel`=0 (MD5) computes res = B + rotl(A+F+W, s). It then sets A←D, B←res, C←B, D←C, and E does not change.
- R6: A step with `alg_sel`=1 (SHA-1) computes res = rotl(A,5) + F + E + W and ignores `rot_amt`. It then sets A←res, B←A, C←rotl(B,30), D←C, E←D.
- R7: A step with `alg_sel`=2 (RIPEMD-160 lane) computes res = E + rotl(A+F+W, s). It then sets A←E, B←res, C←B, D←rotl(C,10), E←D.
- R8: Every addition is taken modulo 2^32, and carries out of bit 31 are dropped.
- R9: A step with `alg_sel`=3 (unassigned) leaves all five registers unchanged.
- R10: A rotate amount of 0 passes the sum through with no rotation, and 31 rotates by 31 places.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alg_sel | input | 2 | Algorithm: 0 MD5, 1 SHA-1, 2 RIPEMD-160 lane, 3 unassigned |
| fn_sel | input | 3 | Boolean-function code |
| wk_in | input | 32 | Message word already added to the round constant |
| rot_amt | input | 5 | Variable left-rotate amount |
| load | input | 1 | Load the chaining value |
| cv_in | input | 160 | Chaining value, A in the top word |
| step_en | input | 1 | Perform one step |
| a_q | output | 32 | Register A |
| b_q | output | 32 | Register B |
| c_q | output | 32 | Register C |
| d_q | output | 32 | Register D |
| e_q | output | 32 | Register E |

## Verification
A chaining-value load and a step request can arrive in the same cycle. This happens when a sequencer starts a new block without a gap. The bench asserts `load` and `step_en` together under every algorithm code, with non-trivial step inputs. It expects the registers to hold exactly `cv_in` afterwards and to show no trace of the step. The random phase also raises both strobes at the same time now and then, and checks every such cycle against the load-only prediction.

// File: rtl/hstep_pkg.sv
package hstep_pkg;

    localparam int WORD_W   = 32;
    localparam int ROT_W    = $clog2(WORD_W);
    localparam int NUM_REGS = 5;
    localparam int CV_W     = WORD_W * NUM_REGS;
    localparam int SHA_AROT = 5;
    localparam int SHA_BROT = 30;
    localparam int RMD_CROT = 10;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ALG_MD5  = 2'd0,
        ALG_SHA1 = 2'd1,
        ALG_RMD  = 2'd2,
        ALG_NONE = 2'd3
    } alg_e;

    typedef enum logic [2:0] {
        FN_XOR3   = 3'd0,
        FN_CHOOSE = 3'd1,
        FN_MAJ    = 3'd2,
        FN_SELD   = 3'd3,
        FN_CBND   = 3'd4,
        FN_BNCD   = 3'd5,
        FN_BCND   = 3'd6,
        FN_ZERO   = 3'd7
    } fn_e;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } wregs_t;

    // Variable left rotate by doubling the word and taking a window.
    function automatic word_t rotl_var(input word_t x, input logic [ROT_W-1:0] s);
        logic [2*WORD_W-1:0] dbl;
        dbl = {x, x} << s;
        return dbl[2*WORD_W-1:WORD_W];
    endfunction

    function automatic word_t rotl_const(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

endpackage

// File: rtl/hstep_boolfn.sv
module hstep_boolfn
    import hstep_pkg::*;
(
    input  fn_e   fn,
    input  word_t b,
    input  word_t c,
    input  word_t d,
    output word_t f
);
    always_comb begin
        unique case (fn)
            FN_XOR3:   f = b ^ c ^ d;
            FN_CHOOSE: f = (b & c) | (~b & d);
            FN_MAJ:    f = (b & c) | (b & d) | (c & d);
            FN_SELD:   f = (b & d) | (c & ~d);
            FN_CBND:   f = c ^ (b | ~d);
            FN_BNCD:   f = (b | ~c) ^ d;
            FN_BCND:   f = b ^ (c | ~d);
            default:   f = '0;
        endcase
    end
endmodule

// File: rtl/hstep_datapath.sv
module hstep_datapath
    import hstep_pkg::*;
(
    input  wregs_t            cur,
    input  alg_e              alg,
    input  fn_e               fn,
    input  word_t             wk,
    input  logic [ROT_W-1:0]  rot,
    output wregs_t            nxt
);
    word_t fval;
    word_t first_add;
    word_t sum1;
    word_t rotated;
    word_t base;
    word_t res;

    hstep_boolfn u_fn (
        .fn (fn),
        .b  (cur.b),
        .c  (cur.c),
        .d  (cur.d),
        .f  (fval)
    );

    // One adder chain shared by every algorithm; only operand picks differ.
    always_comb begin
        first_add = (alg == ALG_SHA1) ? cur.e : cur.a;
        sum1      = fval + first_add + wk;
        rotated   = (alg == ALG_SHA1) ? sum1 : rotl_var(sum1, rot);
        unique case (alg)
            ALG_MD5:  base = cur.b;
            ALG_SHA1: base = rotl_const(cur.a, SHA_AROT);
            default:  base = cur.e;
        endcase
        res = base + rotated;
    end

    always_comb begin
        nxt = cur;
        unique case (alg)
            ALG_MD5: begin
                nxt.a = cur.d;
                nxt.b = res;
                nxt.c = cur.b;
                nxt.d = cur.c;
            end
            ALG_SHA1: begin
                nxt.a = res;
                nxt.b = cur.a;
                nxt.c = rotl_const(cur.b, SHA_BROT);
                nxt.d = cur.c;
                nxt.e = cur.d;
            end
            ALG_RMD: begin
                nxt.a = cur.e;
                nxt.b = res;
                nxt.c = cur.b;
                nxt.d = rotl_const(cur.c, RMD_CROT);
                nxt.e = cur.d;
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/hash_step_core.sv
module hash_step_core
    import hstep_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          alg_sel,
    input  logic [2:0]          fn_sel,
    input  logic [WORD_W-1:0]   wk_in,
    input  logic [ROT_W-1:0]    rot_amt,
    input  logic                load,
    input  logic [CV_W-1:0]     cv_in,
    input  logic                step_en,
    output logic [WORD_W-1:0]   a_q,
    output logic [WORD_W-1:0]   b_q,
    output logic [WORD_W-1:0]   c_q,
    output logic [WORD_W-1:0]   d_q,
    output logic [WORD_W-1:0]   e_q
);
    wregs_t cur;
    wregs_t nxt;

    hstep_datapath u_dp (
        .cur (cur),
        .alg (alg_e'(alg_sel)),
        .fn  (fn_e'(fn_sel)),
        .wk  (wk_in),
        .rot (rot_amt),
        .nxt (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)          cur <= '0;
        else if (load)    cur <= wregs_t'(cv_in);
        else if (step_en) cur <= nxt;
    end

    assign a_q = cur.a;
    assign b_q = cur.b;
    assign c_q = cur.c;
    assign d_q = cur.d;
    assign e_q = cur.e;

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (a_q == '0 && b_q == '0 && c_q == '0 && d_q == '0 && e_q == '0));

    a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> ({a_q, b_q, c_q, d_q, e_q} == $past(cv_in)));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !step_en) |=> ($stable(a_q) && $stable(b_q) && $stable(c_q)
                                 && $stable(d_q) && $stable(e_q)));

    a_r5_md5_shift: assert property (@(posedge clk) disable iff (rst)
        (!load && step_en && alg_sel == 2'd0) |=>
            (a_q == $past(d_q) && c_q == $past(b_q) && d_q == $past(c_q) && $stable(e_q)));

    a_r6_sha_shift: assert property (@(posedge clk) disable iff (rst)
        (!load && step_en && alg_sel == 2'd1) |=>
            (b_q == $past(a_q) && c_q == {$past(b_q[1:0]), $past(b_q[31:2])}
             && d_q == $past(c_q) && e_q == $past(d_q)));

    a_r7_rmd_shift: assert property (@(posedge clk) disable iff (rst)
        (!load && step_en && alg_sel == 2'd2) |=>
            (a_q == $past(e_q) && c_q == $past(b_q)
             && d_q == {$past(c_q[21:0]), $past(c_q[31:22])} && e_q == $past(d_q)));

    a_r9_unassigned_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && step_en && alg_sel == 2'd3) |=>
            ($stable(a_q) && $stable(b_q) && $stable(c_q) && $stable(d_q) && $stable(e_q)));
endmodule

// File: tb/sim_hash_step_core.sv
module sim_hash_step_core;
    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   alg_sel;
    logic [2:0]   fn_sel;
    logic [31:0]  wk_in;
    logic [4:0]   rot_amt;
    logic         load;
    logic [159:0] cv_in;
    logic         step_en;
    logic [31:0]  a_q, b_q, c_q, d_q, e_q;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [159:0] exp_st;

    always #2 clk = ~clk;

    hash_step_core u0 (
        .clk(clk), .rst(rst), .alg_sel(alg_sel), .fn_sel(fn_sel), .wk_in(wk_in),
        .rot_amt(rot_amt), .load(load), .cv_in(cv_in), .step_en(step_en),
        .a_q(a_q), .b_q(b_q), .c_q(c_q), .d_q(d_q), .e_q(e_q)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        if (n == 0) return x;
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [31:0] bfun(input logic [2:0] f, input logic [31:0] b,
                                         input logic [31:0] c, input logic [31:0] d);
        case (f)
            3'd0: return b ^ c ^ d;
            3'd1: return (b & c) | (~b & d);
            3'd2: return (b & c) | (b & d) | (c & d);
            3'd3: return (b & d) | (c & ~d);
            3'd4: return c ^ (b | ~d);
            3'd5: return (b | ~c) ^ d;
            3'd6: return b ^ (c | ~d);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [159:0] model(input logic [159:0] s, input logic [1:0] alg,
                                           input logic [2:0] f, input logic [31:0] w,
                                           input logic [4:0] r);
        logic [31:0] a, b, c, d, e, fv, res;
        logic [63:0] wide;
        {a, b, c, d, e} = s;
        fv = bfun(f, b, c, d);
        case (alg)
            2'd0: begin
                wide = {32'h0, a} + {32'h0, fv} + {32'h0, w};
                res = b + rl(wide[31:0], int'(r));
                return {d, res, b, c, e};
            end
            2'd1: begin
                wide = {32'h0, rl(a, 5)} + {32'h0, fv} + {32'h0, e} + {32'h0, w};
                res = wide[31:0];
                return {res, a, rl(b, 30), c, d};
            end
            2'd2: begin
                wide = {32'h0, a} + {32'h0, fv} + {32'h0, w};
                res = e + rl(wide[31:0], int'(r));
                return {e, res, b, rl(c, 10), d};
            end
            default: return s;
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [159:0] got;
        got = {a_q, b_q, c_q, d_q, e_q};
        n_checks++;
        if (got !== exp_st) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp_st);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic apply(input logic ld, input logic st, input logic [1:0] alg,
                         input logic [2:0] f, input logic [31:0] w, input logic [4:0] r,
                         input logic [159:0] cv, input string tag);
        load = ld; step_en = st; alg_sel = alg; fn_sel = f;
        wk_in = w; rot_amt = r; cv_in = cv;
        if (ld)      exp_st = cv;
        else if (st) exp_st = model(exp_st, alg, f, w, r);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic string alg_tag(input logic [1:0] alg);
        case (alg)
            2'd0: return "R5";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return "R9";
        endcase
    endfunction

    initial begin : watchdog
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [159:0] seed_cv;
        int unused;
        unused = $urandom(32'h5eed_1234);
        rst = 1'b1; load = 0; step_en = 0; alg_sel = 0; fn_sel = 0;
        wk_in = 0; rot_amt = 0; cv_in = '1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        exp_st = '0;
        compare("R1 reset clears registers");
        rst = 1'b0;

        seed_cv = {32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476, 32'hc3d2e1f0};
        apply(1, 0, 2'd0, 3'd0, 0, 0, seed_cv, "R2 load");
        apply(0, 0, 2'd1, 3'd2, 32'hdeadbeef, 5'd7, '0, "R3 idle hold");
        // load and step in the same cycle under every algorithm code
        for (int al = 0; al < 4; al++)
            apply(1, 1, 2'(al), 3'd1, 32'h12345678, 5'd13,
                  {5{32'(al) * 32'h11111111 + 32'h0f0f0f0f}}, "R2 load beats step");
        // every function code, including the zero code, through MD5
        for (int f = 0; f < 8; f++) begin
            apply(1, 0, 2'd0, 3'd0, 0, 0, seed_cv, "R2 reload");
            apply(0, 1, 2'd0, 3'(f), 32'h0badf00d, 5'd7, '0, "R4 function code");
        end
        // carry overflow on every adder
        apply(1, 0, 2'd0, 3'd0, 0, 0, {5{32'hffffffff}}, "R2 load ones");
        apply(0, 1, 2'd1, 3'd2, 32'hffffffff, 5'd0, '0, "R8 carry dropped sha");
        apply(1, 0, 2'd0, 3'd0, 0, 0, {5{32'hfffffff0}}, "R2 load");
        apply(0, 1, 2'd2, 3'd0, 32'hffffffff, 5'd31, '0, "R8 carry dropped rmd");
        // rotate boundaries
        apply(1, 0, 2'd0, 3'd0, 0, 0, seed_cv, "R2 reload");
        apply(0, 1, 2'd0, 3'd3, 32'h80000001, 5'd0, '0, "R10 rotate zero");
        apply(0, 1, 2'd2, 3'd5, 32'h80000001, 5'd31, '0, "R10 rotate thirtyone");
        apply(0, 1, 2'd3, 3'd4, 32'h13572468, 5'd9, '0, "R9 unassigned code holds");
        apply(0, 1, 2'd1, 3'd6, 32'h2468ace0, 5'd17, '0, "R6 rotate ignored");

        for (int i = 0; i < 3000; i++) begin
            logic ld, st;
            logic [1:0] al;
            ld = ($urandom_range(0, 15) == 0);
            st = ($urandom_range(0, 7) != 0);
            al = 2'($urandom_range(0, 3));
            apply(ld, st, al, 3'($urandom_range(0, 7)), $urandom, 5'($urandom_range(0, 31)),
                  {$urandom, $urandom, $urandom, $urandom, $urandom},
                  ld ? "R2 random load" : (st ? alg_tag(al) : "R3 random idle"));
        end

        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        exp_st = '0;
        compare("R1 reset after activity");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule